// File: doc/BRIEF.md
# PLL Status Flags and Interrupt Request

This block holds the status and change-flag register of a PLL clock generator. Two status inputs arrive from outside the clock domain: whether the PLL is locked, and whether the generator has fallen back to limp-home operation after losing its reference clock. Each input passes through a multi-flop synchroniser. A sticky flag then records every change of the synchronised value, in both directions. Software reads one 8-bit register that shows both live status bits and both flags. It clears a flag by writing 1 to that flag's bit.

While limp-home is active, the lock detector has no reference to work from. For that reason the lock status reads 0 and the lock change flag is held cleared. Two enable inputs gate the flags into a single level-sensitive interrupt request.

Top module: `pll_status_irq`

## Requirements
- R1: After reset, rd_data reads 0x00 and irq is low.
- R2: Bit 6 of rd_data (lock status) follows the lock input two clock edges after it changes. Bit 0 (limp status) follows the limp input the same way.
- R3: Bit 7 of rd_data (lock change flag) goes to 1 three clock edges after the lock input rises, and also three edges after it falls.
- R4: Bit 1 of rd_data (limp change flag) goes to 1 three clock edges after the limp input enters the active state, and also three edges after it leaves it.
- R5: A write with wr_data bit 7 at 1 clears the lock change flag, and a write with bit 1 at 1 clears the limp change flag. A write with the bit at 0 leaves that flag unchanged.
- R6: Writes have no effect on the two status bits. Bits 5 to 2 always read 0.
- R7: While the limp status bit reads 1, the lock status bit and the lock change flag both read 0. Lock input changes made during limp-home leave no flag behind after exit.
- R8: If a change event and a write-1 clear of the same flag fall on the same clock edge, the flag ends up set.
- R9: irq equals (lock change flag AND lock_ie) OR (limp change flag AND limp_ie), as a level.
- R10: A set flag stays set, with no further input activity, until a write-1 clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_async | input | 1 | Asynchronous PLL lock status |
| limp_async | input | 1 | Asynchronous limp-home status |
| lock_ie | input | 1 | Lock change interrupt enable |
| limp_ie | input | 1 | Limp change interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data, 1 in a flag position clears it |
| rd_data | output | 8 | Register read value |
| irq | output | 1 | Interrupt request level |

## Verification
The bound checker checks several rules on every cycle:
- unused bits stay zero;
- limp-home masks both lock bits;
- a change event always leaves the limp flag set, even when a clear arrives on the same edge;
- clears take effect, and flags stay set between clears;
- irq never rises without an enable, and is high whenever an enabled limp flag is set.

Only the bench scenarios can show the exact latencies from an asynchronous input change to the status and flag bits. They also cover:
- flags set by transitions in both directions;
- the absence of a lock flag after lock activity hidden inside limp-home;
- the full sweep of enable combinations against the flags.

// File: rtl/pllst_pkg.sv
package pllst_pkg;
   localparam int CH_LOCK = 0;
   localparam int CH_LIMP = 1;
   localparam int NUM_CH  = 2;
endpackage

// File: rtl/pllst_sync.sv
module pllst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic change_o
);
   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], async_i};
         prev  <= chain[STAGES-1];
      end
   end

   assign level_o  = chain[STAGES-1];
   assign change_o = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/pllst_flag.sv
module pllst_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic hold_clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_o <= 1'b0;
      else if (hold_clr_i) flag_o <= 1'b0;
      else if (set_i)      flag_o <= 1'b1;
      else if (clr_i)      flag_o <= 1'b0;
   end
endmodule

// File: rtl/pll_status_irq.sv
module pll_status_irq #(
   parameter int SYNC_STAGES   = 2,
   parameter int REG_W         = 8,
   parameter int LOCK_FLAG_POS = 7,
   parameter int LOCK_STAT_POS = 6,
   parameter int LH_FLAG_POS   = 1,
   parameter int LH_STAT_POS   = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_async,
   input  logic             limp_async,
   input  logic             lock_ie,
   input  logic             limp_ie,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             irq
);
   import pllst_pkg::*;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (LOCK_FLAG_POS >= REG_W || LOCK_STAT_POS >= REG_W ||
          LH_FLAG_POS >= REG_W || LH_STAT_POS >= REG_W) begin : g_bad_pos
         $error("bit position outside register width");
      end
      if (LOCK_FLAG_POS == LOCK_STAT_POS || LOCK_FLAG_POS == LH_FLAG_POS ||
          LOCK_FLAG_POS == LH_STAT_POS || LOCK_STAT_POS == LH_FLAG_POS ||
          LOCK_STAT_POS == LH_STAT_POS || LH_FLAG_POS == LH_STAT_POS) begin : g_dup_pos
         $error("bit positions must be distinct");
      end
   endgenerate

   logic [NUM_CH-1:0] async_vec;
   logic [NUM_CH-1:0] level;
   logic [NUM_CH-1:0] evt;
   logic [NUM_CH-1:0] clr;
   logic [NUM_CH-1:0] hold;
   logic [NUM_CH-1:0] flag;
   logic              lh_evt;
   logic              limp_on;
   logic              unused_wr;

   assign async_vec[CH_LOCK] = lock_async;
   assign async_vec[CH_LIMP] = limp_async;
   assign limp_on            = level[CH_LIMP];
   assign lh_evt             = evt[CH_LIMP];

   assign clr[CH_LOCK]  = wr_en & wr_data[LOCK_FLAG_POS];
   assign clr[CH_LIMP]  = wr_en & wr_data[LH_FLAG_POS];
   assign hold[CH_LOCK] = limp_on;
   assign hold[CH_LIMP] = 1'b0;
   assign unused_wr     = ^wr_data;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         pllst_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_i  (async_vec[c]),
            .level_o  (level[c]),
            .change_o (evt[c])
         );
         pllst_flag u_flag (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (evt[c]),
            .clr_i      (clr[c]),
            .hold_clr_i (hold[c]),
            .flag_o     (flag[c])
         );
      end
   endgenerate

   logic lock_flag_vis;
   assign lock_flag_vis = flag[CH_LOCK] & ~limp_on;

   always_comb begin
      rd_data                = '0;
      rd_data[LOCK_FLAG_POS] = lock_flag_vis;
      rd_data[LOCK_STAT_POS] = level[CH_LOCK] & ~limp_on;
      rd_data[LH_FLAG_POS]   = flag[CH_LIMP];
      rd_data[LH_STAT_POS]   = limp_on;
   end

   assign irq = (lock_flag_vis & lock_ie) | (flag[CH_LIMP] & limp_ie);
endmodule

// File: rtl/pll_status_irq_chk.sv
module pll_status_irq_chk #(
   parameter int REG_W         = 8,
   parameter int LOCK_FLAG_POS = 7,
   parameter int LOCK_STAT_POS = 6,
   parameter int LH_FLAG_POS   = 1,
   parameter int LH_STAT_POS   = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lock_ie,
   input logic             limp_ie,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic [REG_W-1:0] rd_data,
   input logic             irq,
   input logic             lh_evt
);
   localparam logic [REG_W-1:0] USED_MASK =
      REG_W'((1 << LOCK_FLAG_POS) | (1 << LOCK_STAT_POS) |
             (1 << LH_FLAG_POS) | (1 << LH_STAT_POS));

   // R6
   unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~USED_MASK) == '0);

   // R7
   limp_masks_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[LH_STAT_POS] |-> (!rd_data[LOCK_STAT_POS] && !rd_data[LOCK_FLAG_POS]));

   // R8
   evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lh_evt |=> rd_data[LH_FLAG_POS]);

   // R5
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[LH_FLAG_POS] && !lh_evt) |=> !rd_data[LH_FLAG_POS]);

   // R10
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[LH_FLAG_POS] && !(wr_en && wr_data[LH_FLAG_POS])) |=> rd_data[LH_FLAG_POS]);

   // R9
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_ie && !limp_ie) |-> !irq);

   // R9
   irq_limp_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[LH_FLAG_POS] && limp_ie) |-> irq);
endmodule

bind pll_status_irq pll_status_irq_chk #(
   .REG_W(REG_W), .LOCK_FLAG_POS(LOCK_FLAG_POS), .LOCK_STAT_POS(LOCK_STAT_POS),
   .LH_FLAG_POS(LH_FLAG_POS), .LH_STAT_POS(LH_STAT_POS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lock_ie(lock_ie), .limp_ie(limp_ie),
   .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .lh_evt(lh_evt)
);

// File: tb/pll_status_irq_tb.sv
module pll_status_irq_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lock_async = 1'b0;
   logic       limp_async = 1'b0;
   logic       lock_ie = 1'b0;
   logic       limp_ie = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   pll_status_irq u_dut (
      .clk(clk), .rst_n(rst_n), .lock_async(lock_async), .limp_async(limp_async),
      .lock_ie(lock_ie), .limp_ie(limp_ie), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   // change inputs at a falling edge, then let three rising edges pass
   task automatic drive(input logic lk, input logic lh);
      @(negedge clk);
      lock_async = lk;
      limp_async = lh;
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = 8'h00;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic cur_lock;
      logic [7:0] exp;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset rd", rd_data, 8'h00);
      chk("R1 reset irq", {7'b0, irq}, 8'h00);
      rst_n = 1'b1;

      // lock rise: status after two edges, flag after three
      @(negedge clk);
      lock_async = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R2 lock status latency", rd_data, 8'h40);
      @(posedge clk);
      @(negedge clk);
      chk("R3 flag on rise", rd_data, 8'hC0);
      chk("R9 no irq when disabled", {7'b0, irq}, 8'h00);
      repeat (10) @(posedge clk);
      @(negedge clk);
      chk("R10 flag sticky", rd_data, 8'hC0);
      wr(8'h7F);
      chk("R5 write 0 keeps flag", rd_data, 8'hC0);
      wr(8'hFF);
      chk("R6 status not written", rd_data, 8'h40);
      drive(1'b0, 1'b0);
      chk("R3 flag on fall", rd_data, 8'h80);
      wr(8'h80);
      chk("R5 clear lock flag", rd_data, 8'h00);

      // limp-home entry with lock high
      drive(1'b1, 1'b0);
      wr(8'h80);
      chk("R2 lock reads 1", rd_data, 8'h40);
      @(negedge clk);
      limp_async = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R7 R2 limp masks lock", rd_data, 8'h01);
      @(posedge clk);
      @(negedge clk);
      chk("R4 flag on entry", rd_data, 8'h03);
      drive(1'b0, 1'b1);
      chk("R7 lock fall hidden", rd_data, 8'h03);
      drive(1'b1, 1'b1);
      chk("R7 lock rise hidden", rd_data, 8'h03);
      wr(8'h02);
      chk("R5 clear limp flag", rd_data, 8'h01);
      drive(1'b1, 1'b0);
      chk("R4 R7 flag on exit no lock flag", rd_data, 8'h42);

      // interrupt sweep
      drive(1'b0, 1'b0);
      chk("R3 both flags", rd_data, 8'h82);
      for (int e = 0; e < 4; e++) begin
         @(negedge clk);
         lock_ie = e[0];
         limp_ie = e[1];
         #1;
         chk("R9 irq both flags", {7'b0, irq}, {7'b0, e[0] | e[1]});
      end
      wr(8'h02);
      for (int e = 0; e < 4; e++) begin
         @(negedge clk);
         lock_ie = e[0];
         limp_ie = e[1];
         #1;
         chk("R9 irq lock flag only", {7'b0, irq}, {7'b0, e[0]});
      end
      wr(8'h80);
      for (int e = 0; e < 4; e++) begin
         @(negedge clk);
         lock_ie = e[0];
         limp_ie = e[1];
         #1;
         chk("R9 irq no flags", {7'b0, irq}, 8'h00);
      end
      lock_ie = 1'b0;
      limp_ie = 1'b0;

      // same-edge event and clear
      @(negedge clk);
      lock_async = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = 8'h80;
      @(posedge clk);
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = 8'h00;
      chk("R8 set beats clear", rd_data, 8'hC0);
      wr(8'h80);

      // write pattern sweep against both flags
      cur_lock = 1'b1;
      for (int p = 0; p < 16; p++) begin
         logic [7:0] d;
         d = {p[3], p[2], 1'b1, p[0], 1'b0, p[1], p[1], p[0]};
         drive(cur_lock, 1'b1);
         drive(cur_lock, 1'b0);
         cur_lock = ~cur_lock;
         drive(cur_lock, 1'b0);
         chk("R3 R4 flags before write", rd_data, {2'b10, 4'b0, 2'b10} | {1'b0, cur_lock, 6'b0});
         wr(d);
         exp = {~d[7], cur_lock, 4'b0, ~d[1], 1'b0};
         chk("R5 R6 write pattern", rd_data, exp);
         wr(8'hFF);
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule